// File: doc/BRIEF.md
# Timer Interrupt Pending Tracker

This block sits between the expiry events of a periodic timer and an interrupt controller. It keeps a count of timer expirations that have not yet been delivered, and it issues a one-cycle interrupt pulse only after the previous pulse has been acknowledged. This lets a slow or masked consumer fall behind without losing ticks, or with ticks merged, depending on a policy input.

A reinjection enable level picks the policy. When it is high, every tick adds to the backlog, and each acknowledge that leaves work behind triggers the next pulse. When it is low, a tick counts only if the backlog is empty, so missed ticks are merged into one. An acknowledge that finds the backlog empty is treated as spurious and absorbed. Reprogramming the timer or unmasking the interrupt drops the whole backlog and re-opens the delivery gate.

Top module: `tick_backlog_irq`

## Requirements
- R1: After reset the interrupt output is low, the backlog is zero and the delivery gate is open, so the first tick produces a pulse.
- R2: A tick adds one to the backlog when reinjection is enabled or the backlog is zero. A tick arriving with reinjection disabled and a non-zero backlog has no effect.
- R3: A pulse is issued only while the delivery gate is open, and issuing one closes the gate. A further attempt made while the gate is closed is dropped without a pulse.
- R4: Each interrupt pulse on `irq_o` is high for exactly one clock cycle.
- R5: An acknowledge lowers the backlog by one. An acknowledge while the backlog is zero leaves it at zero.
- R6: An acknowledge that leaves the backlog above zero schedules a new delivery attempt.
- R7: Every acknowledge opens the delivery gate.
- R8: A reprogram strobe or an unmask strobe sets the backlog to zero, opens the gate and cancels any scheduled attempt. In that cycle it takes priority over a tick or an acknowledge.
- R9: The backlog saturates at 2^CNT_W-1 instead of wrapping.
- R10: When a delivery attempt and an acknowledge fall in the same cycle, the pulse is issued one cycle later.
- R11: A counted tick sampled at clock edge k raises `irq_o` at edge k+1, provided the gate is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timer expiry event, one cycle |
| ack_i | input | 1 | Acknowledge pulse from the interrupt controller |
| unmask_i | input | 1 | Interrupt unmask event, clears the backlog |
| reinject_en_i | input | 1 | High: accumulate missed ticks; low: merge them |
| reprog_i | input | 1 | Timer reprogram strobe, clears the backlog |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with CNT_W set to 2, so the backlog tops out at 3. Five consecutive ticks therefore overrun the counter, and a run of acknowledges afterwards shows whether the backlog held at 3 or wrapped. The small width also keeps the spurious-acknowledge case observable: a decrement that wrapped the counter would leave a large backlog that keeps producing pulses on later acknowledges.

// File: rtl/tbi_pkg.sv
package tbi_pkg;

   // Widest backlog counter the block accepts
   localparam int unsigned TBI_MAX_CNT_W = 16;

   // Events the two datapath halves share in one cycle
   typedef struct packed {
      logic tick;
      logic ack;
      logic clear;
   } tbi_evt_t;

endpackage

// File: rtl/tbi_backlog.sv
module tbi_backlog
   import tbi_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  tbi_evt_t evt_i,
   input  logic     reinject_en_i,
   output logic     counted_o,
   output logic     more_left_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W:0]   CNT_MAX_X = {1'b0, CNT_MAX};

   if (CNT_W < 1 || CNT_W > TBI_MAX_CNT_W) begin : g_bad_width
      $error("tbi_backlog: CNT_W out of range");
   end

   logic [CNT_W-1:0] pend_q, pend_d;
   logic [CNT_W:0]   sum_w, after_w;
   logic             inc_w, dec_w;

   always_comb begin
      inc_w   = evt_i.tick && !evt_i.clear && (reinject_en_i || (pend_q == '0));
      sum_w   = {1'b0, pend_q} + {{CNT_W{1'b0}}, inc_w};
      dec_w   = evt_i.ack && !evt_i.clear && (sum_w != '0);
      after_w = sum_w - {{CNT_W{1'b0}}, dec_w};
      if (evt_i.clear)
         pend_d = '0;
      else if (after_w > CNT_MAX_X)
         pend_d = CNT_MAX;
      else
         pend_d = after_w[CNT_W-1:0];
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) pend_q <= '0;
      else         pend_q <= pend_d;
   end

   assign counted_o   = inc_w;
   assign more_left_o = evt_i.ack && !evt_i.clear && (pend_d != '0);

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q == CNT_MAX && evt_i.tick && !evt_i.ack && !evt_i.clear)
      |=> (pend_q == CNT_MAX)); // R9

   AST_SPURIOUS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q == '0 && evt_i.ack && !evt_i.tick && !evt_i.clear)
      |=> (pend_q == '0)); // R5

   AST_CLEAR_BACKLOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i.clear |=> (pend_q == '0)); // R8

   AST_COALESCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q != '0 && !reinject_en_i && evt_i.tick && !evt_i.ack && !evt_i.clear)
      |=> $stable(pend_q)); // R2

endmodule

// File: rtl/tbi_deliver.sv
module tbi_deliver
   import tbi_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  tbi_evt_t evt_i,
   input  logic     arm_i,
   output logic     irq_o
);

   logic try_q, acked_q, irq_q;
   logic fire_w;

   // An attempt meeting an acknowledge waits one cycle
   assign fire_w = try_q && acked_q && !evt_i.ack && !evt_i.clear;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         try_q   <= 1'b0;
         acked_q <= 1'b1;
         irq_q   <= 1'b0;
      end else begin
         try_q <= !evt_i.clear && (arm_i || (try_q && evt_i.ack));
         if (evt_i.clear || evt_i.ack)
            acked_q <= 1'b1;
         else if (fire_w)
            acked_q <= 1'b0;
         irq_q <= fire_w;
      end
   end

   assign irq_o = irq_q;

   AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q |=> !irq_q); // R4

   AST_GATE_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q |-> !acked_q); // R3

   AST_ACK_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i.ack |=> acked_q); // R7

   AST_DEFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (try_q && evt_i.ack && !evt_i.clear) |=> (try_q && !irq_q)); // R10

   AST_CLEAR_CANCELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i.clear |=> (acked_q && !try_q && !irq_q)); // R8

endmodule

// File: rtl/tick_backlog_irq.sv
module tick_backlog_irq
   import tbi_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic ack_i,
   input  logic unmask_i,
   input  logic reinject_en_i,
   input  logic reprog_i,
   output logic irq_o
);

   tbi_evt_t evt_w;
   logic     counted_w, more_left_w;

   assign evt_w.tick  = tick_i;
   assign evt_w.ack   = ack_i;
   assign evt_w.clear = unmask_i || reprog_i;

   tbi_backlog #(.CNT_W(CNT_W)) u_backlog (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .evt_i         (evt_w),
      .reinject_en_i (reinject_en_i),
      .counted_o     (counted_w),
      .more_left_o   (more_left_w)
   );

   tbi_deliver u_deliver (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_w),
      .arm_i  (counted_w || more_left_w),
      .irq_o  (irq_o)
   );

   AST_RESET_QUIET: assert property (@(posedge clk_i)
      !rst_ni |=> !irq_o); // R1

endmodule

// File: tb/tick_backlog_irq_bench.sv
module tick_backlog_irq_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, ack = 1'b0, unmask = 1'b0, reinj = 1'b0, reprog = 1'b0;
   logic irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tick_backlog_irq #(.CNT_W(2)) u_tick_backlog_irq (
      .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .ack_i (ack),
      .unmask_i (unmask), .reinject_en_i (reinj), .reprog_i (reprog),
      .irq_o (irq)
   );

   // {reinject, tick, ack, unmask, reprog, expected irq after the edge}
   localparam logic [5:0] VEC [26] = '{
      6'b110000, 6'b100001, 6'b110000, 6'b100000, 6'b101000, 6'b100001,
      6'b101000, 6'b101000, 6'b110000, 6'b100001, 6'b101000, 6'b100000,
      6'b010000, 6'b000001, 6'b010000, 6'b001000, 6'b000000,
      6'b110000, 6'b110001, 6'b110000, 6'b100010, 6'b100000,
      6'b101000, 6'b100000, 6'b110000, 6'b100001
   };

   task automatic check(input string req, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: irq_o=%0b expected %0b", req, got, exp);
      end
   endtask

   task automatic step(input logic rj, input logic tk, input logic ak,
                       input logic um, input logic rp, output logic got);
      reinj = rj; tick = tk; ack = ak; unmask = um; reprog = rp;
      @(posedge clk);
      #2;
      got = irq;
      tick = 1'b0; ack = 1'b0; unmask = 1'b0; reprog = 1'b0;
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: irq_o=%0b expected run to finish", irq);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic g;
      int pulses;
      repeat (3) @(posedge clk);
      #2;
      check("R1 in reset", irq, 1'b0);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         step(1, 0, 0, 0, 0, g);
         check("R1 idle after reset", g, 1'b0);
      end

      // Vector walk, starting from the reset state
      for (int i = 0; i < 26; i++) begin
         step(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], g);
         check($sformatf("table R2 R3 R4 R5 R6 R7 R11 row %0d", i), g, VEC[i][0]);
      end

      // R8: unmask drops backlog and reopens the gate
      step(1, 0, 0, 0, 1, g);
      step(1, 1, 0, 0, 0, g);
      step(1, 0, 0, 0, 0, g);
      check("R8 first pulse", g, 1'b1);
      step(1, 1, 0, 0, 0, g);
      step(1, 0, 0, 0, 0, g);
      check("R3 gate closed", g, 1'b0);
      step(1, 0, 0, 1, 0, g);
      check("R8 unmask cycle", g, 1'b0);
      step(1, 1, 0, 0, 0, g);
      step(1, 0, 0, 0, 0, g);
      check("R8 gate reopened by unmask", g, 1'b1);

      // R8: clear wins over a same-cycle tick
      step(1, 1, 0, 0, 1, g);
      check("R8 clear with tick", g, 1'b0);
      step(1, 0, 0, 0, 0, g);
      check("R8 tick ignored under clear", g, 1'b0);
      step(1, 0, 1, 0, 0, g);
      step(1, 0, 0, 0, 0, g);
      check("R8 backlog zero after clear", g, 1'b0);

      // R10: attempt meeting an acknowledge is served one cycle later
      step(1, 0, 0, 0, 1, g);
      step(1, 1, 0, 0, 0, g);
      step(1, 0, 1, 0, 0, g);
      check("R10 no pulse with ack", g, 1'b0);
      step(1, 0, 0, 0, 0, g);
      check("R10 deferred pulse", g, 1'b1);
      step(1, 0, 0, 0, 0, g);
      check("R4 pulse ends", g, 1'b0);

      // R9: five ticks into a 2-bit backlog, then drain with acknowledges
      step(1, 0, 0, 0, 1, g);
      for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, g);
      step(1, 0, 0, 0, 0, g);
      pulses = 0;
      for (int i = 0; i < 3; i++) begin
         step(1, 0, 1, 0, 0, g);
         if (g) pulses++;
         step(1, 0, 0, 0, 0, g);
         if (g) pulses++;
      end
      n_chk++;
      if (pulses != 2) begin
         n_fail++;
         $display("FAIL R9 saturation: pulses=%0d expected 2", pulses);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule